// File: doc/BRIEF.md
# Sixteen-bit multi-mode PWM timer

This block is a 16-bit timer/counter with one counter core. A 4-bit waveform mode selects how the counter moves, where its TOP value comes from, when a new compare value takes effect, and at which point the overflow pulse fires. The counter can run as a free-running sawtooth, as a clear-on-compare sawtooth, as a fast PWM sawtooth, or as an up/down triangle for the phase-correct and phase-and-frequency-correct PWM modes. TOP is either fixed (0x00FF, 0x01FF, 0x03FF, 0xFFFF) or taken from compare register A or from the capture/TOP register.

The counter moves only on cycles where the `tick` enable is high, so an external prescaler sets the rate. Software writes reach the block as single-cycle write strobes with data. These strobes are always accepted in the cycle they are high. No stream interface is present, so there is no back-pressure. The mode field is split across two control words. Its two low bits are bits 1:0 of `ctrl_a`, and its two high bits are bits 4:3 of `ctrl_b`. Every output is registered.

Top module: `timer_pwm16`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `count` is 0, `ovf_pulse`, `match_pulse` and `pwm_out` are 0, and both the compare register and the capture register are 0. The counter direction is up.
- R2: The mode is {`ctrl_b[4]`, `ctrl_b[3]`, `ctrl_a[1]`, `ctrl_a[0]`}. All other control bits have no effect.
- R3: On a cycle with `tick` low, `count` and `pwm_out` keep their values, and `ovf_pulse` and `match_pulse` are 0 in the following cycle.
- R4: Mode 0 adds one per tick, passes 0xFFFF and wraps to 0. `ovf_pulse` is high in the cycle right after the tick taken at 0xFFFF. `pwm_out` toggles on each compare match.
- R5: Modes 4 and 12 count up and return to 0 after the tick taken at TOP. TOP is compare register A in mode 4 and the capture register in mode 12. Overflow is reported only after the tick taken at 0xFFFF, compare writes act at once, and `pwm_out` toggles on each match.
- R6: The fast PWM modes (5, 6, 7, 14, 15) count 0..TOP and wrap. Overflow is reported after the tick at TOP. `pwm_out` is set on that wrap tick and cleared on a match tick, and when both happen on the same tick the set wins. Mode 14 takes TOP from the capture register, mode 15 from compare register A.
- R7: The dual-slope modes (1, 2, 3, 8, 9, 10, 11) count up to TOP, turn down on the tick at TOP, and turn up on the tick at 0 while falling. Overflow is reported after that bottom turn. A match while rising clears `pwm_out` and a match while falling sets it. TOP comes from the capture register in modes 8 and 10 and from compare register A in modes 9 and 11.
- R8: In modes 1–3, 5–11, 14 and 15, a compare write goes to a buffer. The buffer is copied to the active compare value on the TOP turn in modes 1, 2, 3, 10 and 11, on the bottom turn in modes 8 and 9, and on the wrap tick in the fast PWM modes. In modes 0, 4, 12 and 13 the write becomes active in the next cycle.
- R9: Modes 1 and 5 use TOP 0x00FF, modes 2 and 6 use 0x01FF, and modes 3 and 7 use 0x03FF.
- R10: `match_pulse` is high in the cycle right after a tick taken while `count` equals the active compare value.
- R11: In mode 13, ticks leave `count`, the direction and `pwm_out` unchanged, and no pulse is produced.
- R12: The new `count` value and the pulses from a tick appear together in the cycle after that tick. A pulse lasts one cycle unless the next tick causes it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable for this cycle |
| ctrl_a | input | 8 | Control word holding the low mode bits at 1:0 |
| ctrl_b | input | 8 | Control word holding the high mode bits at 4:3 |
| cmp_wr | input | 1 | Write strobe for compare register A |
| cmp_wdata | input | 16 | Compare write data |
| cap_wr | input | 1 | Write strobe for the capture/TOP register |
| cap_wdata | input | 16 | Capture/TOP write data |
| count | output | 16 | Current counter value |
| ovf_pulse | output | 1 | One-cycle overflow event |
| match_pulse | output | 1 | One-cycle compare-match event |
| pwm_out | output | 1 | Waveform output |

## Verification
The checker assumes that `rst` is driven synchronously. It also assumes that the mode seen on a tick cycle is the mode in force for that tick. It does not assume that the mode stays fixed afterwards. Its bound checks use only fixed-TOP modes and the reserved mode, so no assumption about register-defined TOP values is needed. The bench resets before each random segment and keeps register-defined TOP values at 2 or above, so a dual-slope count never meets a zero TOP. A few mode switches in the middle of a segment then test how the counter behaves when it sits above a freshly lowered TOP.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  typedef enum logic [2:0] {TS_MAX, TS_FIX8, TS_FIX9, TS_FIX10, TS_CMPA, TS_CAPT} top_src_e;
  typedef enum logic [1:0] {SH_SAW, SH_FAST, SH_DUAL} shape_e;
  typedef enum logic [1:0] {UP_NOW, UP_TOP, UP_BOT} upd_e;
  typedef enum logic [1:0] {FL_MAX, FL_TOP, FL_BOT} flg_e;

  typedef struct packed {
    top_src_e top_src;
    shape_e   shape;
    upd_e     upd;
    flg_e     flg;
    logic     hold;
  } mode_cfg_t;

  // Mode number to counter behaviour; code 13 freezes the counter.
  function automatic mode_cfg_t decode_mode(input logic [3:0] m);
    mode_cfg_t c;
    c = '{top_src: TS_MAX, shape: SH_SAW, upd: UP_NOW, flg: FL_MAX, hold: 1'b0};
    case (m)
      4'd1, 4'd2, 4'd3: begin
        c.top_src = top_src_e'({1'b0, m[1:0]});
        c.shape   = SH_DUAL;
        c.upd     = UP_TOP;
        c.flg     = FL_BOT;
      end
      4'd4: c.top_src = TS_CMPA;
      4'd5, 4'd6, 4'd7: begin
        c.top_src = top_src_e'({1'b0, m[1:0]});
        c.shape   = SH_FAST;
        c.upd     = UP_BOT;
        c.flg     = FL_TOP;
      end
      4'd8, 4'd9, 4'd10, 4'd11: begin
        c.top_src = m[0] ? TS_CMPA : TS_CAPT;
        c.shape   = SH_DUAL;
        c.upd     = m[1] ? UP_TOP : UP_BOT;
        c.flg     = FL_BOT;
      end
      4'd12: c.top_src = TS_CAPT;
      4'd13: c.hold = 1'b1;
      4'd14, 4'd15: begin
        c.top_src = m[0] ? TS_CMPA : TS_CAPT;
        c.shape   = SH_FAST;
        c.upd     = UP_BOT;
        c.flg     = FL_TOP;
      end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tmr_mode_decode.sv
`timescale 1ns/1ps
module tmr_mode_decode
  import tmr_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int LO_POS = 0,
  parameter int HI_POS = 3
) (
  input  logic [CTRL_W-1:0] ctrl_a,
  input  logic [CTRL_W-1:0] ctrl_b,
  output mode_cfg_t         cfg
);
  localparam logic [CTRL_W-1:0] LO_MASK = CTRL_W'(3) << LO_POS;
  localparam logic [CTRL_W-1:0] HI_MASK = CTRL_W'(3) << HI_POS;

  logic [3:0] mode_num;
  logic       unused_ctrl_bits;

  assign mode_num = {ctrl_b[HI_POS+1:HI_POS], ctrl_a[LO_POS+1:LO_POS]};
  assign cfg      = decode_mode(mode_num);
  assign unused_ctrl_bits = ^{ctrl_a & ~LO_MASK, ctrl_b & ~HI_MASK};
endmodule

// File: rtl/tmr_cmp_bank.sv
`timescale 1ns/1ps
module tmr_cmp_bank
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_cfg_t        cfg,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             cap_wr,
  input  logic [CNT_W-1:0] cap_wdata,
  input  logic             upd_stb,
  output logic [CNT_W-1:0] cmp_act,
  output logic [CNT_W-1:0] top_val
);
  localparam logic [CNT_W-1:0] TOP_FULL = '1;
  localparam logic [CNT_W-1:0] TOP_B8   = CNT_W'(255);
  localparam logic [CNT_W-1:0] TOP_B9   = CNT_W'(511);
  localparam logic [CNT_W-1:0] TOP_B10  = CNT_W'(1023);

  logic [CNT_W-1:0] cmp_buf_q, cmp_act_q, cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_buf_q <= '0;
      cmp_act_q <= '0;
      cap_q     <= '0;
    end else begin
      if (cmp_wr) cmp_buf_q <= cmp_wdata;
      if (cmp_wr && cfg.upd == UP_NOW) cmp_act_q <= cmp_wdata;
      else if (upd_stb)                cmp_act_q <= cmp_buf_q;
      if (cap_wr) cap_q <= cap_wdata;
    end
  end

  always_comb begin
    case (cfg.top_src)
      TS_FIX8:  top_val = TOP_B8;
      TS_FIX9:  top_val = TOP_B9;
      TS_FIX10: top_val = TOP_B10;
      TS_CMPA:  top_val = cmp_act_q;
      TS_CAPT:  top_val = cap_q;
      default:  top_val = TOP_FULL;
    endcase
  end

  assign cmp_act = cmp_act_q;
endmodule

// File: rtl/tmr_count_core.sv
`timescale 1ns/1ps
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  mode_cfg_t        cfg,
  input  logic [CNT_W-1:0] top_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_up,
  output logic             ovf_stb,
  output logic             match_stb,
  output logic             upd_stb,
  output logic             wrap_stb
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] FULL = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;
  logic             step, is_dual;
  logic             at_top, turn_top, turn_bot;
  logic             evt_top, evt_bot, evt_max;

  assign step     = tick && !cfg.hold;
  assign is_dual  = (cfg.shape == SH_DUAL);
  assign at_top   = (cnt_q == top_val);
  assign turn_top = up_q && (cnt_q >= top_val);
  assign turn_bot = !up_q && (cnt_q == '0);
  assign evt_top  = is_dual ? turn_top : at_top;
  assign evt_bot  = is_dual ? turn_bot : at_top;
  assign evt_max  = (cnt_q == FULL);

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (is_dual) begin
      if (turn_top) begin
        cnt_d = (cnt_q == '0) ? '0 : cnt_q - ONE;
        up_d  = 1'b0;
      end else if (turn_bot) begin
        cnt_d = (top_val == '0) ? '0 : ONE;
        up_d  = 1'b1;
      end else begin
        cnt_d = up_q ? cnt_q + ONE : cnt_q - ONE;
      end
    end else begin
      cnt_d = at_top ? '0 : cnt_q + ONE;
      up_d  = 1'b1;
    end
  end

  always_comb begin
    case (cfg.flg)
      FL_MAX:  ovf_stb = step && evt_max;
      FL_TOP:  ovf_stb = step && evt_top;
      default: ovf_stb = step && evt_bot;
    endcase
    case (cfg.upd)
      UP_TOP:  upd_stb = step && evt_top;
      UP_BOT:  upd_stb = step && evt_bot;
      default: upd_stb = 1'b0;
    endcase
  end

  assign match_stb = step && (cnt_q == cmp_val);
  assign wrap_stb  = step && evt_bot;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (step) begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt    = cnt_q;
  assign cnt_up = up_q;
endmodule

// File: rtl/tmr_wave_out.sv
`timescale 1ns/1ps
module tmr_wave_out
  import tmr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  shape_e shape,
  input  logic   cnt_up,
  input  logic   ovf_stb,
  input  logic   match_stb,
  input  logic   wrap_stb,
  output logic   pwm_out,
  output logic   ovf_pulse,
  output logic   match_pulse
);
  logic pwm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q       <= 1'b0;
      ovf_pulse   <= 1'b0;
      match_pulse <= 1'b0;
    end else begin
      ovf_pulse   <= ovf_stb;
      match_pulse <= match_stb;
      case (shape)
        SH_FAST: begin
          if (wrap_stb)       pwm_q <= 1'b1;
          else if (match_stb) pwm_q <= 1'b0;
        end
        SH_DUAL: if (match_stb) pwm_q <= !cnt_up;
        default: if (match_stb) pwm_q <= !pwm_q;
      endcase
    end
  end

  assign pwm_out = pwm_q;
endmodule

// File: rtl/timer_pwm16.sv
`timescale 1ns/1ps
module timer_pwm16
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CTRL_W-1:0] ctrl_a,
  input  logic [CTRL_W-1:0] ctrl_b,
  input  logic              cmp_wr,
  input  logic [CNT_W-1:0]  cmp_wdata,
  input  logic              cap_wr,
  input  logic [CNT_W-1:0]  cap_wdata,
  output logic [CNT_W-1:0]  count,
  output logic              ovf_pulse,
  output logic              match_pulse,
  output logic              pwm_out
);
  mode_cfg_t        cfg;
  logic [CNT_W-1:0] cmp_act, top_val;
  logic             cnt_up, ovf_stb, match_stb, upd_stb, wrap_stb;

  tmr_mode_decode #(.CTRL_W(CTRL_W), .LO_POS(0), .HI_POS(3)) u_dec (
    .ctrl_a (ctrl_a),
    .ctrl_b (ctrl_b),
    .cfg    (cfg)
  );

  tmr_cmp_bank #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg),
    .cmp_wr    (cmp_wr),
    .cmp_wdata (cmp_wdata),
    .cap_wr    (cap_wr),
    .cap_wdata (cap_wdata),
    .upd_stb   (upd_stb),
    .cmp_act   (cmp_act),
    .top_val   (top_val)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cfg       (cfg),
    .top_val   (top_val),
    .cmp_val   (cmp_act),
    .cnt       (count),
    .cnt_up    (cnt_up),
    .ovf_stb   (ovf_stb),
    .match_stb (match_stb),
    .upd_stb   (upd_stb),
    .wrap_stb  (wrap_stb)
  );

  tmr_wave_out u_wave (
    .clk         (clk),
    .rst         (rst),
    .shape       (cfg.shape),
    .cnt_up      (cnt_up),
    .ovf_stb     (ovf_stb),
    .match_stb   (match_stb),
    .wrap_stb    (wrap_stb),
    .pwm_out     (pwm_out),
    .ovf_pulse   (ovf_pulse),
    .match_pulse (match_pulse)
  );
endmodule

// File: rtl/timer_pwm16_chk.sv
`timescale 1ns/1ps
module timer_pwm16_chk #(
  parameter int CNT_W  = 16,
  parameter int CTRL_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [CTRL_W-1:0] ctrl_a,
  input logic [CTRL_W-1:0] ctrl_b,
  input logic [CNT_W-1:0]  count,
  input logic              ovf_pulse,
  input logic              match_pulse,
  input logic              pwm_out
);
  logic [3:0] mode_seen;
  logic       unused_chk_bits;

  assign mode_seen       = {ctrl_b[4:3], ctrl_a[1:0]};
  assign unused_chk_bits = ^{ctrl_a, ctrl_b};

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count) && $stable(pwm_out) && !ovf_pulse && !match_pulse);

  assert_reserved_freeze_R11: assert property (@(posedge clk) disable iff (rst)
    (tick && mode_seen == 4'd13) |=> $stable(count) && $stable(pwm_out) && !ovf_pulse && !match_pulse);

  assert_normal_step_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && mode_seen == 4'd0) |=> count == $past(count) + CNT_W'(1));

  assert_normal_ovf_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && mode_seen == 4'd0) |=> ovf_pulse == ($past(count) == {CNT_W{1'b1}}));

  assert_fast8_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (tick && mode_seen == 4'd5 && count == CNT_W'(255)) |=> count == '0 && ovf_pulse);

  assert_dual8_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && mode_seen == 4'd1 && count <= CNT_W'(255)) |=> count <= CNT_W'(255));
endmodule

bind timer_pwm16 timer_pwm16_chk #(.CNT_W(CNT_W), .CTRL_W(CTRL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .ctrl_a      (ctrl_a),
  .ctrl_b      (ctrl_b),
  .count       (count),
  .ovf_pulse   (ovf_pulse),
  .match_pulse (match_pulse),
  .pwm_out     (pwm_out)
);

// File: tb/timer_pwm16_test.sv
`timescale 1ns/1ps
module timer_pwm16_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [7:0]  ctrl_a = '0, ctrl_b = '0;
  logic        cmp_wr = 1'b0, cap_wr = 1'b0;
  logic [15:0] cmp_wdata = '0, cap_wdata = '0;
  wire  [15:0] count;
  wire         ovf_pulse, match_pulse, pwm_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  timer_pwm16 uut (
    .clk(clk), .rst(rst), .tick(tick), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .cap_wr(cap_wr), .cap_wdata(cap_wdata),
    .count(count), .ovf_pulse(ovf_pulse), .match_pulse(match_pulse), .pwm_out(pwm_out)
  );

  // ---------------- expected-value model built from the requirements ----------------
  function automatic int f_kind(input logic [3:0] m); // 0 sawtooth, 1 fast, 2 dual, 3 frozen
    if (m == 4'd13) return 3;
    if (m inside {4'd5, 4'd6, 4'd7, 4'd14, 4'd15}) return 1;
    if (m inside {4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11}) return 2;
    return 0;
  endfunction

  function automatic int f_upd(input logic [3:0] m); // 0 at once, 1 at TOP, 2 at BOTTOM
    if (m inside {4'd1, 4'd2, 4'd3, 4'd10, 4'd11}) return 1;
    if (m inside {4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd14, 4'd15}) return 2;
    return 0;
  endfunction

  function automatic int f_flg(input logic [3:0] m); // 0 MAX, 1 TOP, 2 BOTTOM
    if (f_kind(m) == 1) return 1;
    if (f_kind(m) == 2) return 2;
    return 0;
  endfunction

  function automatic logic [15:0] f_top(input logic [3:0] m, input logic [15:0] a, input logic [15:0] c);
    case (m)
      4'd1, 4'd5: return 16'h00FF;
      4'd2, 4'd6: return 16'h01FF;
      4'd3, 4'd7: return 16'h03FF;
      4'd4, 4'd9, 4'd11, 4'd15: return a;
      4'd8, 4'd10, 4'd12, 4'd14: return c;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic string f_tag(input logic [3:0] m);
    case (m)
      4'd0: return "R4";
      4'd4, 4'd12: return "R5";
      4'd14, 4'd15: return "R6";
      4'd5, 4'd6, 4'd7, 4'd1, 4'd2, 4'd3: return "R9";
      4'd13: return "R11";
      default: return "R7";
    endcase
  endfunction

  logic [15:0] m_cnt, m_buf, m_act, m_icr, mv_top, mv_nc;
  logic        m_up, m_ovf, m_match, m_pwm;
  logic [3:0]  mv_md;
  logic        mv_adv, mv_tt, mv_tb, mv_etop, mv_ebot, mv_hit, mv_ovf, mv_upd, mv_nu;
  int          mv_k;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = '0; m_buf = '0; m_act = '0; m_icr = '0;
      m_up = 1'b1; m_ovf = 1'b0; m_match = 1'b0; m_pwm = 1'b0;
    end else begin
      mv_md   = {ctrl_b[4:3], ctrl_a[1:0]};
      mv_k    = f_kind(mv_md);
      mv_top  = f_top(mv_md, m_act, m_icr);
      mv_adv  = tick && (mv_k != 3);
      mv_tt   = m_up && (m_cnt >= mv_top);
      mv_tb   = !m_up && (m_cnt == 16'd0);
      mv_etop = (mv_k == 2) ? mv_tt : (m_cnt == mv_top);
      mv_ebot = (mv_k == 2) ? mv_tb : (m_cnt == mv_top);
      mv_hit  = mv_adv && (m_cnt == m_act);
      case (f_flg(mv_md))
        0: mv_ovf = mv_adv && (m_cnt == 16'hFFFF);
        1: mv_ovf = mv_adv && mv_etop;
        default: mv_ovf = mv_adv && mv_ebot;
      endcase
      case (f_upd(mv_md))
        1: mv_upd = mv_adv && mv_etop;
        2: mv_upd = mv_adv && mv_ebot;
        default: mv_upd = 1'b0;
      endcase
      mv_nc = m_cnt; mv_nu = m_up;
      if (mv_adv) begin
        if (mv_k == 2) begin
          if (mv_tt) begin mv_nc = (m_cnt == 0) ? 16'd0 : m_cnt - 16'd1; mv_nu = 1'b0; end
          else if (mv_tb) begin mv_nc = (mv_top == 0) ? 16'd0 : 16'd1; mv_nu = 1'b1; end
          else mv_nc = m_up ? m_cnt + 16'd1 : m_cnt - 16'd1;
        end else begin
          mv_nc = (m_cnt == mv_top) ? 16'd0 : m_cnt + 16'd1;
          mv_nu = 1'b1;
        end
      end
      if (mv_k == 1) begin
        if (mv_adv && mv_ebot) m_pwm = 1'b1;
        else if (mv_hit)       m_pwm = 1'b0;
      end else if (mv_k == 2) begin
        if (mv_hit) m_pwm = !m_up;
      end else if (mv_hit) m_pwm = !m_pwm;
      if (cmp_wr && f_upd(mv_md) == 0) m_act = cmp_wdata;
      else if (mv_upd)                 m_act = m_buf;
      if (cmp_wr) m_buf = cmp_wdata;
      if (cap_wr) m_icr = cap_wdata;
      m_ovf = mv_ovf; m_match = mv_hit; m_cnt = mv_nc; m_up = mv_nu;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check_all(input string tag);
    n_tests++;
    if ({count, ovf_pulse, match_pulse, pwm_out} !== {m_cnt, m_ovf, m_match, m_pwm}) begin
      n_fail++;
      $display("FAIL %s: count=%h ovf=%b match=%b pwm=%b expected count=%h ovf=%b match=%b pwm=%b",
               tag, count, ovf_pulse, match_pulse, pwm_out, m_cnt, m_ovf, m_match, m_pwm);
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input string tag);
    tick = t;
    @(negedge clk);
    check_all(tag);
    cmp_wr = 1'b0;
    cap_wr = 1'b0;
  endtask

  task automatic run(input int n, input logic t, input string tag);
    for (int i = 0; i < n; i++) cyc(t, tag);
  endtask

  task automatic set_mode(input logic [3:0] m);
    ctrl_a = {6'b0, m[1:0]};
    ctrl_b = {3'b0, m[3:2], 3'b0};
  endtask

  task automatic do_reset();
    rst = 1'b1; tick = 1'b0; cmp_wr = 1'b0; cap_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] rm;
    void'($urandom(32'd20240611));

    // R1: reset state
    do_reset();
    chk("R1", "count", 32'(count), 32'h0);
    chk("R1", "pulses+pwm", {29'b0, ovf_pulse, match_pulse, pwm_out}, 32'h0);

    // R4: mode 0 full wrap
    set_mode(4'd0);
    run(65535, 1'b1, "R4");
    chk("R4", "count at max", 32'(count), 32'hFFFF);
    chk("R4", "no early ovf", 32'(ovf_pulse), 32'h0);
    cyc(1'b1, "R4");
    chk("R4", "wrap count", 32'(count), 32'h0);
    chk("R4", "ovf after max", 32'(ovf_pulse), 32'h1);
    cyc(1'b0, "R12");
    chk("R12", "ovf one cycle", 32'(ovf_pulse), 32'h0);
    chk("R3", "count held", 32'(count), 32'h0);

    // R9 / R6: fast PWM fixed 8-bit
    do_reset();
    set_mode(4'd5);
    run(255, 1'b1, "R9");
    chk("R9", "count at 0xFF", 32'(count), 32'hFF);
    cyc(1'b1, "R9");
    chk("R9", "wrap to 0", 32'(count), 32'h0);
    chk("R6", "ovf at TOP", 32'(ovf_pulse), 32'h1);
    chk("R6", "pwm set on wrap", 32'(pwm_out), 32'h1);
    cyc(1'b1, "R6");
    chk("R6", "pwm cleared on match", 32'(pwm_out), 32'h0);

    // R9 / R7: phase correct fixed 8-bit, turn at TOP
    do_reset();
    set_mode(4'd1);
    run(255, 1'b1, "R9");
    chk("R9", "count at 0xFF", 32'(count), 32'hFF);
    cyc(1'b1, "R7");
    chk("R7", "turn down", 32'(count), 32'hFE);

    // R11: frozen mode
    set_mode(4'd13);
    run(10, 1'b1, "R11");
    chk("R11", "count frozen", 32'(count), 32'hFE);
    chk("R11", "no pulses", {30'b0, ovf_pulse, match_pulse}, 32'h0);

    // R3: idle
    set_mode(4'd1);
    run(5, 1'b0, "R3");
    chk("R3", "count held", 32'(count), 32'hFE);

    // R2: extra control bits ignored (mode 1 with junk)
    ctrl_a = 8'b1010_1101;
    ctrl_b = 8'b1110_0110;
    cyc(1'b1, "R2");
    chk("R2", "still falling", 32'(count), 32'hFD);
    run(20, 1'b1, "R2");

    // R8 / R10 / R7: mode 10, compare buffered until TOP
    do_reset();
    set_mode(4'd10);
    cap_wdata = 16'd20; cap_wr = 1'b1;
    cmp_wdata = 16'd5;  cmp_wr = 1'b1;
    cyc(1'b0, "R8");
    cyc(1'b1, "R10");
    chk("R10", "match at active 0", 32'(match_pulse), 32'h1);
    run(5, 1'b1, "R8");
    chk("R8", "count", 32'(count), 32'd6);
    chk("R8", "buffered value not yet active", 32'(match_pulse), 32'h0);
    run(30, 1'b1, "R8");
    chk("R8", "count falling", 32'(count), 32'd4);
    chk("R8", "match after TOP copy", 32'(match_pulse), 32'h1);
    chk("R7", "pwm set on falling match", 32'(pwm_out), 32'h1);
    run(5, 1'b1, "R7");
    chk("R7", "bottom turn", 32'(count), 32'd1);
    chk("R7", "ovf at bottom", 32'(ovf_pulse), 32'h1);

    // Random segments
    for (int seg = 0; seg < 40; seg++) begin
      do_reset();
      rm = 4'($urandom % 16);
      ctrl_a = {6'($urandom), rm[1:0]};
      ctrl_b = {3'($urandom), rm[3:2], 3'($urandom)};
      cap_wdata = 16'(2 + $urandom % 30); cap_wr = 1'b1;
      cmp_wdata = 16'($urandom % 34);     cmp_wr = 1'b1;
      cyc(1'b0, f_tag(rm));
      for (int i = 0; i < 260; i++) begin
        if (($urandom % 20) == 0) begin cmp_wr = 1'b1; cmp_wdata = 16'($urandom % 34); end
        if (($urandom % 40) == 0) begin cap_wr = 1'b1; cap_wdata = 16'(2 + $urandom % 30); end
        if (i == 130 && ($urandom % 3) == 0) begin
          rm = 4'($urandom % 16);
          ctrl_a = {6'($urandom), rm[1:0]};
          ctrl_b = {3'($urandom), rm[3:2], 3'($urandom)};
        end
        cyc(($urandom % 10) < 7, f_tag(rm));
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule